// File: doc/BRIEF.md
# Selectable-Ratio Sample Word Demultiplexer

This block spreads a stream of 11-bit sample words, each 10 data bits plus one flag bit (an out-of-range marker, for instance), across four parallel output ports A, B, C and D. One word is taken on every rising edge of `clk`. A static ratio select groups the words into frames of two or four. Each finished frame is handed to the ports, so a downstream consumer can run at a half or a quarter of the sample rate.

A frame-ready strobe goes with the output words. In full-rate form it is a clock whose rising edge marks each new frame. In half-rate form it toggles once per frame, so both of its edges are meaningful. A second mode choice sets when the ports update. They can all load together, or the odd ports (B, D) can load half an output period after the even ports (A, C). In the staggered case each port's flag output is replaced by that port's own clock, which follows the same full-rate or half-rate rule.

The active-low asynchronous reset starts the block. After reset the frame alignment is held with no further synchronisation. The three mode inputs may change only while reset is asserted.

Top module: `word_demux`

## Requirements
- R1: While reset is held, every port data output, every `out_aux` bit and `data_ready` read 0, and the next word sampled after release is the first word of a frame.
- R2: With `ratio_sel`=1 and `stagger_en`=0, four consecutive words w0..w3 appear on ports A..D. Port k is `out_data[k*10 +: 10]`, with bit 0 as the LSB. All four ports change in the clock cycle that follows the edge sampling w3.
- R3: With `ratio_sel`=0, w0 goes to port A and w1 to port B. Both change after the edge sampling w1. Ports C and D keep their values (0 since reset), and in staggered mode their port clocks stay 0.
- R4: With `stagger_en`=0, `out_aux[k]` carries the flag bit of the word held in port k.
- R5: With `stagger_en`=1, ports A and C load at the frame-completion edge. Ports B and D load N/2 input cycles later (N is 2 or 4) and show the previous frame until then.
- R6: With `stagger_en`=1, `out_aux[k]` is port k's clock. In full-rate mode it rises in the cycle port k loads and stays high for N/2 cycles. In half-rate mode it toggles on each load of port k.
- R7: With `half_rate_dr`=0, `data_ready` goes high in the cycle a frame loads into port A. It stays high for N/2 cycles, then low for N/2 cycles.
- R8: With `half_rate_dr`=1, `data_ready` toggles exactly once per frame load and holds its level at all other times.
- R9: Frame boundaries recur every N words for as long as the block runs, with no resynchronisation.
- R10: `ratio_sel`, `stagger_en` and `half_rate_dr` change only while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one word per rising edge |
| rst_n | input | 1 | Active-low asynchronous master reset |
| ratio_sel | input | 1 | 0 = 1:2 (ports A, B), 1 = 1:4 (ports A..D) |
| stagger_en | input | 1 | 0 = ports load together, 1 = odd ports load half an output period late |
| half_rate_dr | input | 1 | 0 = full-rate rising-edge strobe, 1 = toggle per frame |
| in_data | input | 10 | Data bits of the incoming word |
| in_flag | input | 1 | Extra flag bit of the incoming word |
| out_data | output | 40 | Port k data at bits [k*10 +: 10], A = 0 to D = 3 |
| out_aux | output | 4 | Per port: flag bit (simultaneous) or port clock (staggered) |
| data_ready | output | 1 | Frame-ready strobe |

## Verification
Two events can fall in the same cycle. In staggered mode the odd ports publish the previous frame at the same edge where the word collector overwrites that frame's staging slot with a new word. In 1:2 staggered mode, port B's late load also coincides with the first word of the next frame. The bench provokes both by streaming distinct, continuously changing words in all eight mode combinations. A scoreboard rebuilds from the requirement timing which word each port must hold after every edge, and a stale-versus-new mix-up shows as a wrong port value.

// File: rtl/wdmx_pkg.sv
package wdmx_pkg;
    typedef enum logic {
        STROBE_FULL = 1'b0,
        STROBE_HALF = 1'b1
    } strobe_style_e;

    function automatic bit is_odd_port(input int idx);
        return (idx % 2) == 1;
    endfunction
endpackage

// File: rtl/wdmx_collect.sv
module wdmx_collect #(
    parameter int WORD_W = 11,
    parameter int NPORT  = 4,
    localparam int CNT_W = $clog2(NPORT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ratio4,
    input  logic                         stagger,
    input  logic [WORD_W-1:0]            in_word,
    output logic [NPORT-1:0][WORD_W-1:0] merged_words,
    output logic [NPORT-1:0][WORD_W-1:0] held_words,
    output logic                         pub_even,
    output logic                         pub_odd
);
    typedef struct packed {
        logic [CNT_W-1:0]                cnt;
        logic                            started;
        logic [NPORT-1:0][WORD_W-1:0]    stage;
    } col_t;

    col_t col_d, col_q;
    logic [CNT_W-1:0] last_slot;
    logic [CNT_W-1:0] odd_slot;

    always_comb begin
        last_slot = ratio4 ? CNT_W'(NPORT - 1) : CNT_W'(1);
        odd_slot  = ratio4 ? CNT_W'(NPORT / 2 - 1) : '0;
        col_d = col_q;
        col_d.stage[col_q.cnt] = in_word;
        if (col_q.cnt == last_slot) begin
            col_d.cnt     = '0;
            col_d.started = 1'b1;
        end else begin
            col_d.cnt = col_q.cnt + CNT_W'(1);
        end
        for (int j = 0; j < NPORT; j++) begin
            merged_words[j] = (col_q.cnt == CNT_W'(j)) ? in_word : col_q.stage[j];
        end
        held_words = col_q.stage;
        pub_even   = (col_q.cnt == last_slot);
        pub_odd    = stagger ? (col_q.started && col_q.cnt == odd_slot) : pub_even;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    // R9
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.cnt <= last_slot);

    // R5
    pub_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stagger |-> !(pub_even && pub_odd));
endmodule

// File: rtl/wdmx_strobe.sv
module wdmx_strobe
    import wdmx_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_rate,
    input  logic          load,
    input  logic [CW-1:0] high_len,
    output logic          level
);
    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] left;
    } stb_t;

    stb_t stb_d, stb_q;
    strobe_style_e style;

    always_comb begin
        style = strobe_style_e'(half_rate);
        stb_d = stb_q;
        if (load) begin
            if (style == STROBE_HALF) begin
                stb_d.lvl = ~stb_q.lvl;
            end else begin
                stb_d.lvl  = 1'b1;
                stb_d.left = high_len - CW'(1);
            end
        end else if (style == STROBE_FULL && stb_q.lvl) begin
            if (stb_q.left == '0) stb_d.lvl  = 1'b0;
            else                  stb_d.left = stb_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= stb_d;
    end

    assign level = stb_q.lvl;

    // R8
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_rate && !load) |=> $stable(level));

    // R7
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_rate && load) |=> level);
endmodule

// File: rtl/word_demux.sv
module word_demux
    import wdmx_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int NPORT  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ratio_sel,
    input  logic                    stagger_en,
    input  logic                    half_rate_dr,
    input  logic [DATA_W-1:0]       in_data,
    input  logic                    in_flag,
    output logic [NPORT*DATA_W-1:0] out_data,
    output logic [NPORT-1:0]        out_aux,
    output logic                    data_ready
);
    localparam int WORD_W = DATA_W + 1;
    localparam int CW     = $clog2(NPORT / 2 + 1);

    typedef struct packed {
        logic [NPORT-1:0][WORD_W-1:0] word;
    } port_t;

    port_t port_d, port_q;

    logic [NPORT-1:0][WORD_W-1:0] merged_words;
    logic [NPORT-1:0][WORD_W-1:0] held_words;
    logic [NPORT-1:0][WORD_W-1:0] src_word;
    logic [NPORT-1:0]             port_load;
    logic [NPORT-1:0]             port_clk;
    logic                         pub_even;
    logic                         pub_odd;
    logic [CW-1:0]                high_len;

    wdmx_collect #(
        .WORD_W (WORD_W),
        .NPORT  (NPORT)
    ) u_collect (
        .clk          (clk),
        .rst_n        (rst_n),
        .ratio4       (ratio_sel),
        .stagger      (stagger_en),
        .in_word      ({in_flag, in_data}),
        .merged_words (merged_words),
        .held_words   (held_words),
        .pub_even     (pub_even),
        .pub_odd      (pub_odd)
    );

    assign high_len = ratio_sel ? CW'(NPORT / 2) : CW'(1);

    always_comb begin
        port_d = port_q;
        for (int k = 0; k < NPORT; k++) begin
            if (is_odd_port(k) && stagger_en) begin
                src_word[k]  = held_words[k];
                port_load[k] = (ratio_sel || k < 2) && pub_odd;
            end else begin
                src_word[k]  = merged_words[k];
                port_load[k] = (ratio_sel || k < 2) && pub_even;
            end
            if (port_load[k]) port_d.word[k] = src_word[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        wdmx_strobe #(.CW(CW)) u_pclk (
            .clk       (clk),
            .rst_n     (rst_n),
            .half_rate (half_rate_dr),
            .load      (port_load[k]),
            .high_len  (high_len),
            .level     (port_clk[k])
        );
        assign out_data[k*DATA_W +: DATA_W] = port_q.word[k][DATA_W-1:0];
        assign out_aux[k] = stagger_en ? port_clk[k] : port_q.word[k][DATA_W];
    end

    wdmx_strobe #(.CW(CW)) u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_rate (half_rate_dr),
        .load      (pub_even),
        .high_len  (high_len),
        .level     (data_ready)
    );

    // R3
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_sel |=> $stable(port_q.word[NPORT-1:2]));

    // R10
    mode_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({ratio_sel, stagger_en, half_rate_dr}));
endmodule

// File: tb/word_demux_test.sv
`timescale 1ns/1ps
module word_demux_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ratio_sel, stagger_en, half_rate_dr;
    logic [9:0]  in_data;
    logic        in_flag;
    logic [39:0] out_data;
    logic [3:0]  out_aux;
    logic        data_ready;

    always #5 clk = ~clk;

    word_demux uut (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .stagger_en(stagger_en),
        .half_rate_dr(half_rate_dr), .in_data(in_data), .in_flag(in_flag),
        .out_data(out_data), .out_aux(out_aux), .data_ready(data_ready)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [10:0] sent_q[$];
    logic [10:0] hist[0:63];
    int e;
    bit m_r4, m_st, m_hf;
    logic [10:0] exp_w[4];
    int last_pub[5];
    bit seen[5];
    bit tog[5];

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at word %0d: actual %h expected %h", tag, what, e, act, exp);
        end
    endtask

    task automatic model_reset();
        e = 0;
        for (int i = 0; i < 4; i++) exp_w[i] = '0;
        for (int i = 0; i < 5; i++) begin last_pub[i] = 0; seen[i] = 0; tog[i] = 0; end
    endtask

    task automatic mark(input int i, input int p);
        last_pub[i] = p; seen[i] = 1; tog[i] = ~tog[i];
    endtask

    function automatic logic exp_clk(input int i, input int h);
        if (m_hf) return tog[i];
        return seen[i] && ((e - last_pub[i]) < h);
    endfunction

    // Scoreboard monitor: pops each sampled word, updates expectations, compares after the edge
    always @(posedge clk) begin
        int n, h, s;
        logic [39:0] xd;
        logic [3:0]  xa;
        if (rst_n && sent_q.size() > 0) begin
            hist[e] = sent_q.pop_front();
            n = m_r4 ? 4 : 2;
            h = n / 2;
            if (e % n == n - 1) begin
                s = e - n + 1;
                for (int j = 0; j < n; j++)
                    if (!m_st || j % 2 == 0) begin exp_w[j] = hist[s + j]; mark(j, e); end
                mark(4, e);
            end
            if (m_st && e >= n - 1 + h && e % n == h - 1) begin
                s = e - h - n + 1;
                for (int j = 1; j < n; j += 2) begin exp_w[j] = hist[s + j]; mark(j, e); end
            end
            #2;
            xd = {exp_w[3][9:0], exp_w[2][9:0], exp_w[1][9:0], exp_w[0][9:0]};
            for (int j = 0; j < 4; j++) xa[j] = m_st ? exp_clk(j, h) : exp_w[j][10];
            if (e >= 24) chk("R9", "port data", 64'(out_data), 64'(xd));
            else chk(m_st ? "R5" : (m_r4 ? "R2" : "R3"), "port data", 64'(out_data), 64'(xd));
            chk(m_st ? "R6" : "R4", "aux bits", 64'(out_aux), 64'(xa));
            chk(m_hf ? "R8" : "R7", "data_ready", 64'(data_ready), 64'(exp_clk(4, h)));
            e++;
        end
    end

    task automatic drive_word(input int i, input int c);
        logic [10:0] w;
        w = {1'b0, 10'((i * 73 + c * 29 + 17) % 1024)};
        w[10] = ((i * 5 + c) % 3) == 0;
        in_data = w[9:0];
        in_flag = w[10];
        sent_q.push_back(w);
    endtask

    task automatic run_combo(input int c);
        @(negedge clk);
        rst_n = 1'b0;
        // R10: modes are changed only while reset is held
        ratio_sel = c[0]; stagger_en = c[1]; half_rate_dr = c[2];
        m_r4 = c[0]; m_st = c[1]; m_hf = c[2];
        model_reset();
        repeat (2) @(negedge clk);
        chk("R1 R10", "reset data", 64'(out_data), 64'd0);
        chk("R1 R10", "reset aux", 64'(out_aux), 64'd0);
        chk("R1 R10", "reset ready", 64'(data_ready), 64'd0);
        drive_word(0, c);
        rst_n = 1'b1;
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            drive_word(i, c);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        ratio_sel = 1'b0; stagger_en = 1'b0; half_rate_dr = 1'b0;
        in_data = '0; in_flag = 1'b0;
        model_reset();
        for (int c = 0; c < 8; c++) run_combo(c);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R9: actual run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule